// File: doc/BRIEF.md
# Platform Status and Control Registers

This block is a 32-bit register slave that sits in a 4 KB window of a board's system map. Software reads it to learn board status and configuration: memory-interface lock and calibration state, which PCIe root ports were built in, the memory size and the clock-divider settings. It also writes one control register to ask for a full system reset.

Two configuration inputs feed the block: the installed memory size in GiB and the interrupt-timer frequency in MHz. The block packs these into the clock-divider and memory-configuration words. All other words are constants. Address decode uses only the low 16 address bits. A request occupies one cycle. Exactly one cycle later a registered response returns the read data, together with a flag that marks an unsupported access size or an unmapped offset.

A write that sets the reset-command bit produces a one-cycle pulse on a dedicated output. The pulse asks the system to reset. It leaves the register block's own state alone.

Top module: `plat_ctl_regs`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `rsp_data`, `bad_access` and `sys_rst_req` are all zero.
- R2: A request with `req_size` other than 4 (bytes) returns zero read data, causes no reset pulse and sets `bad_access` in its response cycle.
- R3: The offsets 0x00, 0x04, 0x08 (build and change identifiers), 0x18 (PCIe status) and 0x10 (reset command) read as 0x00000000 without setting `bad_access`.
- R4: Offset 0x14 (memory-interface status) reads 0x00000005, which is the lock flag in bit 0 plus the calibrated flag in bit 2.
- R5: Offset 0x30 (clock divider) reads timer MHz in bits [15:8] and the value 1 in each of the bytes [7:0], [23:16] and [31:24].
- R6: Offset 0x34 (build configuration) reads 0x0000000E. Bits 1 to 3 are the three PCIe enables and are set. Bit 0, the coherence-unit enable, is clear.
- R7: Offset 0x38 (memory configuration) reads the size in GiB in bits [3:0], ones in bits [15:4] and zeros in bits [31:16].
- R8: A 4-byte write to offset 0x10 with bit 4 of the data set drives `sys_rst_req` high for exactly the response cycle. With bit 4 clear, the write causes no pulse.
- R9: Writes to the read-only offsets leave their read values unchanged and cause no reset pulse.
- R10: Only `req_addr[15:0]` is decoded, so the upper address bits do not change the result.
- R11: A 4-byte access to any offset not listed in R3 to R7 reads zero and sets `bad_access`.
- R12: Every request gives `rsp_valid` high exactly one cycle later. Write responses carry zero data. An idle cycle gives `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [15:0] are decoded |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | 32 | Write data |
| cfg_mem_gib | input | SIZE_W | Installed memory size in GiB |
| cfg_timer_mhz | input | FREQ_W | Timer frequency in MHz |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_data | output | 32 | Read data (zero for writes and rejected accesses) |
| bad_access | output | 1 | Previous request had an unsupported size or offset |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
All outputs are registered one stage after the request. A wrong select code or a wrong packed word therefore shows on `rsp_data` in the very next cycle. A mis-decoded size or offset shows as a wrong `bad_access` in that same cycle. A fault in the reset-command path shows either as a missing pulse, or as a pulse that lasts more than one cycle on an idle bus. The checks therefore sample the response cycle and the cycle after it. They use configuration values whose fields do not overlap, so a byte placed in the wrong lane cannot go unnoticed.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

  localparam int DEC_W   = 16;
  localparam int WORD_W  = 32;
  localparam int FULL_SZ = 4;
  localparam int RST_CMD_BIT = 4;

  localparam logic [DEC_W-1:0] OFS_BUILD    = 16'h0000;
  localparam logic [DEC_W-1:0] OFS_CORE_ID  = 16'h0004;
  localparam logic [DEC_W-1:0] OFS_WRAP_ID  = 16'h0008;
  localparam logic [DEC_W-1:0] OFS_RST_CMD  = 16'h0010;
  localparam logic [DEC_W-1:0] OFS_MEM_STAT = 16'h0014;
  localparam logic [DEC_W-1:0] OFS_PCI_STAT = 16'h0018;
  localparam logic [DEC_W-1:0] OFS_CLK_DIV  = 16'h0030;
  localparam logic [DEC_W-1:0] OFS_BLD_CFG  = 16'h0034;
  localparam logic [DEC_W-1:0] OFS_MEM_CFG  = 16'h0038;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_BUILD,
    SEL_CORE_ID,
    SEL_WRAP_ID,
    SEL_RST_CMD,
    SEL_MEM_STAT,
    SEL_PCI_STAT,
    SEL_CLK_DIV,
    SEL_BLD_CFG,
    SEL_MEM_CFG
  } reg_sel_e;

  localparam logic [WORD_W-1:0] MEM_STAT_WORD = 32'h0000_0005;
  localparam logic [WORD_W-1:0] BLD_CFG_WORD  = 32'h0000_000E;
  localparam logic [WORD_W-1:0] CLK_DIV_BASE  = 32'h0101_0001;
  localparam logic [WORD_W-1:0] MEM_CFG_BASE  = 32'h0000_FFF0;

endpackage

// File: rtl/plat_addr_decode.sv
module plat_addr_decode
  import plat_regs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output reg_sel_e          sel,
  output logic              size_ok
);
  logic [DEC_W-1:0] ofs;
  assign ofs     = addr[DEC_W-1:0];
  assign size_ok = (size == 4'(FULL_SZ));

  always_comb begin
    unique case (ofs)
      OFS_BUILD:    sel = SEL_BUILD;
      OFS_CORE_ID:  sel = SEL_CORE_ID;
      OFS_WRAP_ID:  sel = SEL_WRAP_ID;
      OFS_RST_CMD:  sel = SEL_RST_CMD;
      OFS_MEM_STAT: sel = SEL_MEM_STAT;
      OFS_PCI_STAT: sel = SEL_PCI_STAT;
      OFS_CLK_DIV:  sel = SEL_CLK_DIV;
      OFS_BLD_CFG:  sel = SEL_BLD_CFG;
      OFS_MEM_CFG:  sel = SEL_MEM_CFG;
      default:      sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/plat_read_mux.sv
module plat_read_mux
  import plat_regs_pkg::*;
#(
  parameter int SIZE_W = 4,
  parameter int FREQ_W = 8
) (
  input  reg_sel_e           sel,
  input  logic [SIZE_W-1:0]  mem_gib,
  input  logic [FREQ_W-1:0]  timer_mhz,
  output logic [WORD_W-1:0]  word
);
  localparam int SIZE_FIELD = 4;
  localparam int FREQ_FIELD = 8;
  localparam int FREQ_LSB   = 8;

  logic [WORD_W-1:0] clk_word;
  logic [WORD_W-1:0] mem_word;

  generate
    if (SIZE_W > SIZE_FIELD || FREQ_W > FREQ_FIELD) begin : g_bad_width
      initial $error("plat_read_mux: configuration field wider than its slot");
    end
  endgenerate

  assign clk_word = CLK_DIV_BASE | (WORD_W'(timer_mhz) << FREQ_LSB);
  assign mem_word = MEM_CFG_BASE | WORD_W'(mem_gib);

  always_comb begin
    case (sel)
      SEL_MEM_STAT: word = MEM_STAT_WORD;
      SEL_CLK_DIV:  word = clk_word;
      SEL_BLD_CFG:  word = BLD_CFG_WORD;
      SEL_MEM_CFG:  word = mem_word;
      default:      word = '0;
    endcase
  end
endmodule

// File: rtl/plat_reset_ctl.sv
module plat_reset_ctl
  import plat_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  output logic              pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= wr_hit && wdata[RST_CMD_BIT];
  end

  // R8: a reset request always follows a qualifying write one cycle earlier
  assert_pulse_from_write_R8: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(wr_hit));
endmodule

// File: rtl/plat_ctl_regs.sv
module plat_ctl_regs
  import plat_regs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [SIZE_W-1:0] cfg_mem_gib,
  input  logic [FREQ_W-1:0] cfg_timer_mhz,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              bad_access,
  output logic              sys_rst_req
);
  reg_sel_e          sel;
  logic              size_ok;
  logic [WORD_W-1:0] rd_word;
  logic              rst_wr_hit;

  plat_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (req_addr),
    .size    (req_size),
    .sel     (sel),
    .size_ok (size_ok)
  );

  plat_read_mux #(.SIZE_W(SIZE_W), .FREQ_W(FREQ_W)) u_mux (
    .sel       (sel),
    .mem_gib   (cfg_mem_gib),
    .timer_mhz (cfg_timer_mhz),
    .word      (rd_word)
  );

  assign rst_wr_hit = req_valid && req_write && size_ok && (sel == SEL_RST_CMD);

  plat_reset_ctl u_rst (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (rst_wr_hit),
    .wdata  (req_wdata),
    .pulse  (sys_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      bad_access <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_data   <= (req_valid && !req_write && size_ok) ? rd_word : '0;
      bad_access <= req_valid && (!size_ok || sel == SEL_NONE);
    end
  end

  // R12: no response data or flag without a response
  assert_quiet_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_data == '0) && !bad_access);

  // R12: non-zero data only answers a read request
  assert_data_only_for_read_R12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_data != '0) |-> $past(req_valid && !req_write));

  // R2 / R11: a rejected access never returns data
  assert_bad_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> (rsp_data == '0));

  // R8 / R2: a reset request belongs to an accepted write response
  assert_pulse_is_good_write_R8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> rsp_valid && !bad_access && $past(req_write));
endmodule

// File: tb/test_plat_ctl_regs.sv
module test_plat_ctl_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_size;
  logic [31:0] req_wdata;
  logic [3:0]  cfg_mem_gib;
  logic [7:0]  cfg_timer_mhz;
  logic        rsp_valid, bad_access, sys_rst_req;
  logic [31:0] rsp_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  plat_ctl_regs i_plat_ctl_regs (
    .clk, .rst, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
    .cfg_mem_gib, .cfg_timer_mhz, .rsp_valid, .rsp_data, .bad_access, .sys_rst_req
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Issue one request; sample the registered response one edge later.
  task automatic access(input logic wr, input logic [31:0] addr, input logic [3:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic rd_expect(input string req, input logic [31:0] addr, input logic [31:0] exp,
                           input logic exp_bad);
    access(1'b0, addr, 4'd4, '0);
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " data"}, rsp_data, exp);
    check({req, " bad"}, 32'(bad_access), 32'(exp_bad));
  endtask

  task automatic t_reset_state();
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 rsp_data", rsp_data, 0);
    check("R1 bad_access", 32'(bad_access), 0);
    check("R1 sys_rst_req", 32'(sys_rst_req), 0);
  endtask

  task automatic t_fixed_words();
    rd_expect("R3 build", 32'h0000_0000, 32'h0, 1'b0);
    rd_expect("R3 core id", 32'h0000_0004, 32'h0, 1'b0);
    rd_expect("R3 wrap id", 32'h0000_0008, 32'h0, 1'b0);
    rd_expect("R3 pcie status", 32'h0000_0018, 32'h0, 1'b0);
    rd_expect("R3 reset cmd", 32'h0000_0010, 32'h0, 1'b0);
    rd_expect("R4 mem status", 32'h0000_0014, 32'h0000_0005, 1'b0);
    rd_expect("R6 build cfg", 32'h0000_0034, 32'h0000_000E, 1'b0);
  endtask

  task automatic t_config_words();
    cfg_mem_gib = 4'd2; cfg_timer_mhz = 8'd25;
    rd_expect("R5 clk div 25", 32'h30, {8'h01, 8'h01, 8'd25, 8'h01}, 1'b0);
    rd_expect("R7 mem cfg 2", 32'h38, {16'h0, 12'hFFF, 4'd2}, 1'b0);
    cfg_mem_gib = 4'd1; cfg_timer_mhz = 8'd200;
    rd_expect("R5 clk div 200", 32'h30, {8'h01, 8'h01, 8'd200, 8'h01}, 1'b0);
    rd_expect("R7 mem cfg 1", 32'h38, {16'h0, 12'hFFF, 4'd1}, 1'b0);
  endtask

  task automatic t_sizes();
    for (int i = 0; i < 3; i++) begin
      logic [3:0] sz;
      sz = (i == 0) ? 4'd1 : (i == 1) ? 4'd2 : 4'd8;
      access(1'b0, 32'h14, sz, '0);
      check("R2 narrow read data", rsp_data, 0);
      check("R2 narrow read bad", 32'(bad_access), 1);
    end
    access(1'b1, 32'h10, 4'd2, 32'h0000_0010);
    check("R2 narrow reset write no pulse", 32'(sys_rst_req), 0);
    check("R2 narrow write bad", 32'(bad_access), 1);
    access(1'b1, 32'h10, 4'd8, 32'hFFFF_FFFF);
    check("R2 wide reset write no pulse", 32'(sys_rst_req), 0);
  endtask

  task automatic t_reset_cmd();
    access(1'b1, 32'h10, 4'd4, 32'h0000_0010);
    check("R8 pulse high", 32'(sys_rst_req), 1);
    check("R12 write data zero", rsp_data, 0);
    check("R12 write valid", 32'(rsp_valid), 1);
    @(negedge clk);
    check("R8 pulse one cycle", 32'(sys_rst_req), 0);
    check("R12 idle no valid", 32'(rsp_valid), 0);
    access(1'b1, 32'h10, 4'd4, 32'hFFFF_FFEF);
    check("R8 bit4 clear no pulse", 32'(sys_rst_req), 0);
    access(1'b1, 32'hFFFF_0010, 4'd4, 32'hFFFF_FFFF);
    check("R8 all ones pulse", 32'(sys_rst_req), 1);
  endtask

  task automatic t_read_only();
    cfg_mem_gib = 4'd2; cfg_timer_mhz = 8'd50;
    access(1'b1, 32'h14, 4'd4, 32'h0000_0010);
    check("R9 mem status write no pulse", 32'(sys_rst_req), 0);
    check("R9 mem status write not bad", 32'(bad_access), 0);
    access(1'b1, 32'h38, 4'd4, 32'h0000_0000);
    access(1'b1, 32'h30, 4'd4, 32'h0000_0010);
    check("R9 clk div write no pulse", 32'(sys_rst_req), 0);
    rd_expect("R9 mem status kept", 32'h14, 32'h0000_0005, 1'b0);
    rd_expect("R9 mem cfg kept", 32'h38, 32'h0000_FFF2, 1'b0);
    rd_expect("R9 clk div kept", 32'h30, 32'h0101_3201, 1'b0);
  endtask

  task automatic t_decode();
    rd_expect("R10 alias mem status", 32'hABCD_0014, 32'h0000_0005, 1'b0);
    rd_expect("R10 alias build cfg", 32'h1234_0034, 32'h0000_000E, 1'b0);
    rd_expect("R11 offset 0x0c", 32'h0000_000C, 32'h0, 1'b1);
    rd_expect("R11 offset 0x1014", 32'h0000_1014, 32'h0, 1'b1);
    access(1'b1, 32'h20, 4'd4, 32'h0000_0010);
    check("R11 unmapped write no pulse", 32'(sys_rst_req), 0);
    check("R11 unmapped write bad", 32'(bad_access), 1);
  endtask

  initial begin
    #1_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 4'd4; req_wdata = '0; cfg_mem_gib = 4'd1; cfg_timer_mhz = 8'd100;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_fixed_words();
    t_config_words();
    t_sizes();
    t_reset_cmd();
    t_read_only();
    t_decode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule